// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the target side of a two-wire (I2C-compatible) serial link that gives a host read and write access to an 8-bit-addressed space of configuration bytes. It watches the oversampled clock and data lines and finds bus start, repeated start and stop conditions. After a start it checks the 7-bit device address, which has a direction bit in its LSB. It drives the data line low through an open-drain pull-down enable. When a data byte lands in real storage, it reports that byte on a single-cycle write port.

A write frame carries a register address followed by any number of data bytes. Each byte is stored at once, and an internal pointer then steps by one, wrapping from FFh to 00h. The pointer persists between frames. A read frame therefore starts at the byte after the last one accessed. A random read is a write frame that carries only the register address, followed by a repeated start and a read frame. In a read, each master acknowledge sends the next byte. Storage exists only in two windows, 08h–1Bh and 40h–57h. All other addresses read back as zero and keep nothing.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_pull=0) and wr_en is 0, and all stored bytes read back 00h. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: A START (SDA falling while SCL is high) begins a frame. The slave drives SDA low during the 9th SCL clock of the first byte when its upper seven bits equal the device address 69h. Bit 0 of that byte selects the direction: 1 means read.
- R3: On an address mismatch the slave sends no ACK. Until the next START it acknowledges no byte and stores nothing.
- R4: In a write frame, the byte after the address byte loads the pointer. Every later byte is ACKed and stored at the pointer. For an in-window pointer, wr_en pulses for one cycle with wr_addr equal to the pointer and wr_data equal to the byte. The pointer then increments.
- R5: Bytes written to addresses outside 08h–1Bh and 40h–57h are ACKed but produce no wr_en pulse and are not kept. Such addresses read back as 00h.
- R6: A random read returns the byte at the address sent in the preceding write frame, and that frame stores no data.
- R7: In a read, the slave sends the byte at the pointer MSB first. A master ACK makes it send the byte at the next address. A master NACK ends transmission, and SDA stays released.
- R8: A read frame that follows a STOP returns the byte one above the last address written or read.
- R9: The pointer wraps from FFh to 00h in both writes and reads.
- R10: sda_pull changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired value) |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on SDA |
| wr_en | output | 1 | One-cycle strobe for a stored data byte |
| wr_addr | output | 8 | Register address of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
Every response of the slave is due three sampling clocks after the SCL edge that causes it. That delay comes from two synchronizer flops plus the edge register. The write strobe appears on the same clock as the ACK drive that follows the eighth data bit. The bench changes SDA only in the middle of the SCL low phase and samples SDA in the middle of the high phase, ten clocks away from every SCL edge, so each sample lands well after the three-clock delay has settled. The scoreboard queues each expected write-port item when the byte is sent and matches it against the strobe whenever the strobe fires, so the exact cycle of the strobe does not matter.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the two-wire configuration slave.
package cfg_i2c_pkg;
    // Frame phase: which kind of byte the slave is handling.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_REGA  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } phase_t;
endpackage

// File: rtl/cfg_i2c_sync.sv
// Synchronizes SCL and SDA through STAGES flops and derives SCL edges and
// bus start/stop events from the synchronized values.
// Assumes both lines see the same delay, so their relative order is kept.
module cfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;

    // Shift the raw lines through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_in};
            sda_p <= {sda_p[STAGES-1:0], sda_in};
        end
    end

    // Decode edges and bus conditions from the current and previous samples.
    always_comb begin
        scl_q     = scl_p[STAGES-1];
        sda_q     = sda_p[STAGES-1];
        scl_rise  = scl_q & ~scl_p[STAGES];
        scl_fall  = ~scl_q & scl_p[STAGES];
        start_det = scl_q & scl_p[STAGES] & sda_p[STAGES] & ~sda_q;
        stop_det  = scl_q & scl_p[STAGES] & ~sda_p[STAGES] & sda_q;
    end
endmodule

// File: rtl/cfg_reg_store.sv
// Sparse configuration storage: two address windows backed by flops.
// Reads of unbacked addresses return zero; writes to them are dropped.
module cfg_reg_store #(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int W0_LO = 8'h08,
    parameter int W0_HI = 8'h1B,
    parameter int W1_LO = 8'h40,
    parameter int W1_HI = 8'h57
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rhit
);
    localparam int N0    = W0_HI - W0_LO + 1;
    localparam int N1    = W1_HI - W1_LO + 1;
    localparam int DEPTH = N0 + N1;

    // Register address held by storage entry i.
    function automatic logic [AW-1:0] ent_addr(input int i);
        if (i < N0) return AW'(W0_LO + i);
        else        return AW'(W1_LO + i - N0);
    endfunction

    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [AW-1:0] EADDR = ent_addr(g);
        logic [DW-1:0] q;
        // Hold one configuration byte; load it when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                     q <= '0;
            else if (we && waddr == EADDR)  q <= wdata;
        end
        assign mem[g] = q;
    end

    // Look up the read address; flag whether it is backed by storage.
    always_comb begin
        rdata = '0;
        rhit  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == ent_addr(i)) begin
                rdata = mem[i];
                rhit  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_fsm.sv
// Byte-level protocol engine: address match, ACK generation, register
// pointer with wrap, write strobes and MSB-first read shifting.
// Assumes synchronized inputs; SDA drive changes only on SCL falling edges.
module cfg_i2c_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         DW       = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_q,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_hit,
    output logic [AW-1:0] ptr,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    phase_t        phase, nxt;
    logic [3:0]    bit_cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;

    // Frame sequencer: events take priority, then per-phase bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            nxt      <= PH_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase    <= PH_DEV;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE: ;
                    PH_RDATA: begin
                        if (scl_rise) begin
                            if (bit_cnt == 4'd8) begin
                                ptr     <= ptr + 1'b1;
                                bit_cnt <= 4'd9;
                                if (sda_q) phase <= PH_IDLE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd9) begin
                                tx_sh    <= rd_data;
                                sda_pull <= ~rd_data[DW-1];
                                bit_cnt  <= '0;
                            end else if (bit_cnt == 4'd8) begin
                                sda_pull <= 1'b0;
                            end else begin
                                sda_pull <= ~tx_sh[DW-2];
                                tx_sh    <= tx_sh << 1;
                            end
                        end
                    end
                    default: begin
                        if (scl_rise) begin
                            if (bit_cnt < 4'd8) rx_sh <= {rx_sh[DW-2:0], sda_q};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                if (phase == PH_DEV) begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        sda_pull <= 1'b1;
                                        nxt      <= rx_sh[0] ? PH_RDATA : PH_REGA;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end else if (phase == PH_REGA) begin
                                    ptr      <= rx_sh[AW-1:0];
                                    sda_pull <= 1'b1;
                                    nxt      <= PH_WDATA;
                                end else begin
                                    wr_en    <= rd_hit;
                                    wr_addr  <= ptr;
                                    wr_data  <= rx_sh;
                                    ptr      <= ptr + 1'b1;
                                    sda_pull <= 1'b1;
                                    nxt      <= PH_WDATA;
                                end
                            end else if (bit_cnt == 4'd9) begin
                                phase   <= nxt;
                                bit_cnt <= '0;
                                if (nxt == PH_RDATA) begin
                                    tx_sh    <= rd_data;
                                    sda_pull <= ~rd_data[DW-1];
                                end else begin
                                    sda_pull <= 1'b0;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
// Top of the two-wire configuration slave: synchronizer, protocol engine
// and sparse register store. sda_pull=1 must enable an open-drain pull-down.
module cfg_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         W0_LO       = 8'h08,
    parameter int         W0_HI       = 8'h1B,
    parameter int         W1_LO       = 8'h40,
    parameter int         W1_HI       = 8'h57
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int AW = 8;
    localparam int DW = 8;

    logic          scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [AW-1:0] ptr;
    logic [DW-1:0] rd_data;
    logic          rd_hit;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_i2c_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) i_fsm (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_hit(rd_hit), .ptr(ptr), .sda_pull(sda_pull),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    cfg_reg_store #(
        .AW(AW), .DW(DW), .W0_LO(W0_LO), .W0_HI(W0_HI), .W1_LO(W1_LO), .W1_HI(W1_HI)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(ptr), .rdata(rd_data), .rhit(rd_hit)
    );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
// Protocol checker for cfg_i2c_slave, attached by bind below.
module cfg_i2c_slave_chk #(
    parameter int W0_LO = 8'h08,
    parameter int W0_HI = 8'h1B,
    parameter int W1_LO = 8'h40,
    parameter int W1_HI = 8'h57
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_q,
    input logic       stop_det,
    input logic       sda_pull,
    input logic       wr_en,
    input logic [7:0] wr_addr
);
    logic in_win;
    assign in_win = (int'(wr_addr) >= W0_LO && int'(wr_addr) <= W0_HI) ||
                    (int'(wr_addr) >= W1_LO && int'(wr_addr) <= W1_HI);

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_q);

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    assert_strobe_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> in_win);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_det(stop_det),
    .sda_pull(sda_pull), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_cfg_i2c_slave.sv
// Scoreboard bench: bus tasks queue expected write-port items, a monitor
// pops and compares them on every strobe; read bytes are checked in-line.
module test_cfg_i2c_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull, wr_en;
    logic [7:0] wr_addr, wr_data;
    wire        sda_bus = sda_m & ~sda_pull;

    localparam int Q = 10;

    always #5 clk = ~clk;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int          checks = 0;
    int          errors = 0;
    int          r10_viol = 0;
    bit          done = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] exp_item;
    logic        pull_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit real_addr(input logic [7:0] a);
        return (a >= 8'h08 && a <= 8'h1B) || (a >= 8'h40 && a <= 8'h57);
    endfunction

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; qw;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw; scl_m = 1'b1; qw; b = sda_bus; qw; scl_m = 1'b0; qw;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    // Write frame: register address then data bytes; queue expected strobes.
    task automatic write_frame(input logic [7:0] ra, input logic [7:0] d[$], input string req);
        logic       ack;
        logic [7:0] a;
        bus_start;
        put_byte(8'hD2, ack);
        check(ack == 1'b0, "R2 device address ACK", ack, 0);
        put_byte(ra, ack);
        check(ack == 1'b0, {req, " register address ACK"}, ack, 0);
        a = ra;
        foreach (d[i]) begin
            if (real_addr(a)) exp_q.push_back({a, d[i]});
            put_byte(d[i], ack);
            check(ack == 1'b0, {req, " data ACK"}, ack, 0);
            a = a + 8'd1;
        end
        bus_stop;
    endtask

    // Random read of n bytes from ra; master ACKs all but the last.
    task automatic rand_read(input logic [7:0] ra, input int n, output logic [7:0] got[$]);
        logic       ack;
        logic [7:0] v;
        got = {};
        bus_start;
        put_byte(8'hD2, ack);
        put_byte(ra, ack);
        bus_start;
        put_byte(8'hD3, ack);
        check(ack == 1'b0, "R6 read address ACK", ack, 0);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            got.push_back(v);
        end
        check(sda_bus == 1'b1, "R7 SDA released after NACK", sda_bus, 1);
        bus_stop;
    endtask

    task automatic cur_read(output logic [7:0] v);
        logic ack;
        bus_start;
        put_byte(8'hD3, ack);
        get_byte(1'b0, v);
        bus_stop;
    endtask

    // Scoreboard monitor for the write port.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write strobe", {wr_addr, wr_data}, 0);
            end else begin
                exp_item = exp_q.pop_front();
                check({wr_addr, wr_data} == exp_item, "R4 write port item",
                      {wr_addr, wr_data}, exp_item);
            end
        end
    end

    // R10: SDA drive must not change while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_pull != pull_prev && scl_m) r10_viol++;
        pull_prev <= sda_pull;
    end

    initial begin
        logic [7:0] got[$];
        logic [7:0] v;
        logic       ack;
        logic [7:0] wrap_d[$];

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sda_pull == 1'b0, "R1 reset SDA released", sda_pull, 0);
        check(wr_en == 1'b0, "R1 reset no strobe", wr_en, 0);
        rand_read(8'h45, 1, got);
        check(got[0] == 8'h00, "R1 reset storage value", got[0], 0);

        // R4: burst write into the low window.
        write_frame(8'h08, '{8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R4");

        // R6/R7: random then sequential read.
        rand_read(8'h08, 3, got);
        check(got[0] == 8'hA1, "R6 random read first byte", got[0], 8'hA1);
        check(got[1] == 8'hB2, "R7 sequential second byte", got[1], 8'hB2);
        check(got[2] == 8'hC3, "R7 sequential third byte", got[2], 8'hC3);

        // R8: current-address read continues after last byte read.
        cur_read(v);
        check(v == 8'hD4, "R8 current address read", v, 8'hD4);

        // R3: mismatched device address, then bytes without START.
        bus_start;
        put_byte(8'h54, ack);
        check(ack == 1'b1, "R3 no ACK on mismatch", ack, 1);
        put_byte(8'h08, ack);
        check(ack == 1'b1, "R3 ignored byte not ACKed", ack, 1);
        put_byte(8'h55, ack);
        bus_stop;
        rand_read(8'h08, 1, got);
        check(got[0] == 8'hA1, "R3 storage untouched", got[0], 8'hA1);

        // R5: window edges and a gap address.
        write_frame(8'h1B, '{8'h5A, 8'h66}, "R5");
        write_frame(8'h57, '{8'h33, 8'h44}, "R5");
        rand_read(8'h1B, 2, got);
        check(got[0] == 8'h5A, "R5 last low-window byte", got[0], 8'h5A);
        check(got[1] == 8'h00, "R5 gap address reads zero", got[1], 0);
        rand_read(8'h57, 2, got);
        check(got[0] == 8'h33, "R5 last high-window byte", got[0], 8'h33);
        check(got[1] == 8'h00, "R5 beyond high window reads zero", got[1], 0);

        // R9: write burst from FEh wraps to 00h and reaches 08h.
        wrap_d = {};
        for (int i = 0; i < 11; i++) wrap_d.push_back(8'hE0 + 8'(i));
        write_frame(8'hFE, wrap_d, "R9");
        rand_read(8'hFF, 10, got);
        check(got[9] == 8'hEA, "R9 read wraps FFh to 00h up to 08h", got[9], 8'hEA);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected strobes seen", exp_q.size(), 0);
        check(r10_viol == 0, "R10 SDA drive stable while SCL high", r10_viol, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule